// File: doc/BRIEF.md
# SOF-Locked Hub Frame Timer

This block keeps a hub's local notion of the frame period in step with the host. It runs on the hub clock with a one-cycle bit-time enable. It receives a strobe for each decoded start-of-frame (SOF) and a strobe for each resume event. It measures how many bit times pass between consecutive SOF strobes. Each accepted measurement is loaded into a down-counting frame timer and kept in a stored-interval register. Whenever the frame timer runs down to zero, it reloads from the stored interval. End-of-frame timing therefore carries on when one or two SOFs go missing.

An up-counting interval counter saturates at its all-ones value. A saturated counter means at least one SOF was lost. An SOF that arrives after saturation is not trusted as a measurement. In that case the frame timer is re-aligned from the stored interval. A lock flag rises on the first trusted measurement. Only reset or a resume event clears it. Logic downstream should use the end-of-frame pulse only while the lock flag is high.

All pins are plain control and status signals. There is no data stream, so no valid/ready handshake exists and no back-pressure applies.

Top module: `sof_frame_timer`

## Requirements
- R1: After reset, `frame_count` is 0, `locked` is 0 and `eof_pulse` is 0.
- R2: The first SOF strobe after reset or after a resume event only starts interval measurement. It does not set `locked` and does not load `frame_count`.
- R3: A later SOF strobe that arrives before the interval counter saturates does three things. It loads `frame_count` and the stored interval with the number of bit-time enables seen strictly between the two SOF strobes. It sets `locked`. It restarts measurement from zero.
- R4: Outside SOF loads, `frame_count` decreases by one on each cycle with `bit_en` high. It holds its value on cycles with `bit_en` low.
- R5: On a `bit_en` cycle where `frame_count` is 0 and no SOF load occurs, `frame_count` reloads from the stored interval. With a steady SOF spacing of T enabled cycles, `frame_count` therefore repeats with period T.
- R6: `eof_pulse` is high for exactly one clock. It is high in the cycle where `frame_count` has just stepped from 1 to 0 on a `bit_en` cycle. It is high only while `locked` is high, and never on a cycle that took an SOF load.
- R7: Once locked, the block keeps `locked` high and keeps producing `eof_pulse` once per stored interval while SOF strobes are absent.
- R8: The interval counter is CNT_W bits wide (14 by default) and saturates at 2^CNT_W-1 (16383). An SOF strobe that arrives while it is saturated has four effects. It loads `frame_count` from the stored interval. It leaves the stored interval unchanged. It leaves `locked` unchanged. It restarts measurement from zero.
- R9: When an SOF load and a zero reload fall in the same cycle, the SOF load takes priority. `frame_count` takes the measured value.
- R10: A resume strobe clears `locked` in the next cycle and returns measurement to the state described in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Hub clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle enable per bit time |
| sof_strobe | input | 1 | One-cycle pulse per decoded start-of-frame |
| resume_strobe | input | 1 | One-cycle pulse on a resume event |
| frame_count | output | CNT_W | Live value of the down-counting frame timer |
| locked | output | 1 | High once a trusted interval has been measured |
| eof_pulse | output | 1 | One-cycle end-of-frame marker |

## Verification
The bench targets off-by-one errors in the measured interval. A counter that also counts on the SOF cycle, or that skips the first enable, loads T or T-2 instead of T-1, and the end-of-frame pulse then drifts by a bit time every frame. It also targets the case where a zero reload and an SOF land on the same edge. A design with the wrong priority keeps the old interval instead of the new measurement. It exercises an SOF arriving after the interval counter saturates. A design that ignores saturation loads a wrapped count or clobbers the stored interval, and an unlocked design would lock on garbage. Finally, it checks that missed SOFs keep the lock and the periodic pulse, and that resume drops the lock until two new SOFs have been seen.

// File: rtl/sof_timer_pkg.sv
package sof_timer_pkg;

  localparam int DEF_CNT_W = 14;

  // Source selected for the next frame timer value
  typedef enum logic [2:0] {
    FT_HOLD = 3'd0,
    FT_DEC  = 3'd1,
    FT_WRAP = 3'd2,
    FT_MEAS = 3'd3,
    FT_KEEP = 3'd4
  } ft_src_e;

endpackage

// File: rtl/interval_meter.sv
module interval_meter #(
  parameter int CNT_W = sof_timer_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             sof,
  input  logic             resume,
  output logic [CNT_W-1:0] meas,
  output logic             armed,
  output logic             rolled
);
  localparam logic [CNT_W-1:0] SAT_VAL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cur_q;
  logic             armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      armed_q <= 1'b0;
    end else if (resume) begin
      cur_q   <= '0;
      armed_q <= 1'b0;
    end else if (sof) begin
      cur_q   <= '0;
      armed_q <= 1'b1;
    end else if (bit_en && armed_q && (cur_q != SAT_VAL)) begin
      cur_q <= cur_q + 1'b1;
    end
  end

  assign meas   = cur_q;
  assign armed  = armed_q;
  assign rolled = (cur_q == SAT_VAL);

  AST_SATURATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rolled && !sof && !resume) |=> rolled) else $error("saturation lost"); // R8
  AST_SOF_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !resume) |=> (meas == '0 && armed)) else $error("sof restart"); // R3
  AST_RESUME_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> (!armed && meas == '0)) else $error("resume disarm"); // R10

endmodule

// File: rtl/lock_tracker.sv
module lock_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic set_lock,
  input  logic resume,
  output logic locked
);
  logic lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lock_q <= 1'b0;
    else if (resume)   lock_q <= 1'b0;
    else if (set_lock) lock_q <= 1'b1;
  end

  assign locked = lock_q;

  AST_RESUME_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !locked) else $error("resume kept lock"); // R10
  AST_LOCK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(set_lock)) else $error("lock without measurement"); // R3
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(resume)) else $error("lock dropped"); // R7

endmodule

// File: rtl/frame_downcounter.sv
module frame_downcounter
  import sof_timer_pkg::*;
#(
  parameter int CNT_W = sof_timer_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             load_meas,
  input  logic             load_keep,
  input  logic [CNT_W-1:0] meas,
  input  logic             locked,
  output logic [CNT_W-1:0] count,
  output logic             eof
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] next_q;
  logic             eof_q;
  ft_src_e          src;

  always_comb begin
    if (load_meas)                      src = FT_MEAS;
    else if (load_keep)                 src = FT_KEEP;
    else if (bit_en && cnt_q == '0)     src = FT_WRAP;
    else if (bit_en)                    src = FT_DEC;
    else                                src = FT_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      next_q <= '0;
    end else begin
      case (src)
        FT_MEAS: begin
          cnt_q  <= meas;
          next_q <= meas;
        end
        FT_KEEP: cnt_q <= next_q;
        FT_WRAP: cnt_q <= next_q;
        FT_DEC:  cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eof_q <= 1'b0;
    else        eof_q <= locked && (src == FT_DEC) && (cnt_q == ONE);
  end

  assign count = cnt_q;
  assign eof   = eof_q;

  AST_SOF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_meas |=> (count == $past(meas))) else $error("sof load lost"); // R9
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !load_meas && !load_keep && count != '0) |=> (count == $past(count) - 1'b1))
    else $error("bad decrement"); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !load_meas && !load_keep) |=> $stable(count)) else $error("moved idle"); // R4
  AST_EOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> !eof) else $error("eof too long"); // R6

endmodule

// File: rtl/sof_frame_timer.sv
module sof_frame_timer #(
  parameter int CNT_W = sof_timer_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             sof_strobe,
  input  logic             resume_strobe,
  output logic [CNT_W-1:0] frame_count,
  output logic             locked,
  output logic             eof_pulse
);
  logic [CNT_W-1:0] meas;
  logic             armed;
  logic             rolled;
  logic             sof_ok;
  logic             load_meas;
  logic             load_keep;

  assign sof_ok    = sof_strobe && !resume_strobe && armed;
  assign load_meas = sof_ok && !rolled;
  assign load_keep = sof_ok && rolled;

  interval_meter #(.CNT_W(CNT_W)) u_meter (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_en (bit_en),
    .sof    (sof_strobe),
    .resume (resume_strobe),
    .meas   (meas),
    .armed  (armed),
    .rolled (rolled)
  );

  lock_tracker u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_lock (load_meas),
    .resume   (resume_strobe),
    .locked   (locked)
  );

  frame_downcounter #(.CNT_W(CNT_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .load_meas (load_meas),
    .load_keep (load_keep),
    .meas      (meas),
    .locked    (locked),
    .count     (frame_count),
    .eof       (eof_pulse)
  );

  AST_EOF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    eof_pulse |-> (frame_count == '0 && locked)) else $error("eof misplaced"); // R6
  AST_FIRST_SOF_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_strobe && !armed && !locked) |=> !locked) else $error("locked early"); // R2
  AST_ROLLED_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (load_keep && !locked) |=> !locked) else $error("locked on rollover"); // R8

endmodule

// File: tb/sof_frame_timer_test.sv
module sof_frame_timer_test;
  localparam int W = 14;
  localparam int NV = 5;
  // each row: SOF spacing in enabled cycles, expected loaded interval
  localparam int VEC [NV][2] = '{'{5, 4}, '{9, 8}, '{17, 16}, '{64, 63}, '{250, 249}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b1;
  logic sof_strobe = 1'b0;
  logic resume_strobe = 1'b0;
  logic [W-1:0] frame_count;
  logic locked;
  logic eof_pulse;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sof_frame_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sof_strobe(sof_strobe),
    .resume_strobe(resume_strobe), .frame_count(frame_count),
    .locked(locked), .eof_pulse(eof_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sof_pulse();
    sof_strobe = 1'b1;
    @(negedge clk);
    sof_strobe = 1'b0;
  endtask

  task automatic resume_pulse();
    resume_strobe = 1'b1;
    @(negedge clk);
    resume_strobe = 1'b0;
  endtask

  task automatic lock_at(input int gap);
    resume_pulse();
    sof_pulse();
    repeat (gap - 1) @(negedge clk);
    sof_pulse();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count", int'(frame_count), 0);
    check("R1 locked", int'(locked), 0);
    check("R1 eof", int'(eof_pulse), 0);

    sof_pulse();
    check("R2 no lock", int'(locked), 0);
    check("R2 no load", int'(frame_count), 0);

    for (int i = 0; i < NV; i++) begin
      lock_at(VEC[i][0]);
      check("R3 loaded", int'(frame_count), VEC[i][1]);
      check("R3 locked", int'(locked), 1);
      repeat (VEC[i][1] - 1) @(negedge clk);
      check("R6 early", int'(eof_pulse), 0);
      @(negedge clk);
      check("R6 eof", int'(eof_pulse), 1);
      check("R6 zero", int'(frame_count), 0);
      @(negedge clk);
      check("R6 single", int'(eof_pulse), 0);
      check("R5 wrap", int'(frame_count), VEC[i][1]);
    end

    // R4: enable gating
    lock_at(20);
    bit_en = 1'b0;
    repeat (5) @(negedge clk);
    check("R4 hold", int'(frame_count), 19);
    bit_en = 1'b1;
    @(negedge clk);
    check("R4 step", int'(frame_count), 18);

    // R7: missed SOFs keep lock and period
    lock_at(20);
    for (int k = 0; k < 3; k++) begin
      repeat (19) @(negedge clk);
      check("R7 eof", int'(eof_pulse), 1);
      check("R7 locked", int'(locked), 1);
      @(negedge clk);
    end

    // R9: SOF on the edge where the timer wraps
    lock_at(20);
    repeat (39) @(negedge clk);
    sof_pulse();
    check("R9 priority", int'(frame_count), 39);
    repeat (39) @(negedge clk);
    check("R9 new period", int'(eof_pulse), 1);

    // R8: saturation while locked
    lock_at(20);
    repeat (16400) @(negedge clk);
    sof_pulse();
    check("R8 kept interval", int'(frame_count), 19);
    check("R8 lock kept", int'(locked), 1);
    repeat (19) @(negedge clk);
    check("R8 period", int'(eof_pulse), 1);

    // R8: saturation while unlocked
    resume_pulse();
    sof_pulse();
    repeat (16400) @(negedge clk);
    sof_pulse();
    check("R8 stays unlocked", int'(locked), 0);
    check("R8 from stored", int'(frame_count), 19);
    repeat (9) @(negedge clk);
    sof_pulse();
    check("R8 remeasure", int'(frame_count), 9);
    check("R8 relock", int'(locked), 1);

    // R10: resume drops lock
    lock_at(20);
    resume_pulse();
    check("R10 unlocked", int'(locked), 0);
    sof_pulse();
    check("R10 first sof", int'(locked), 0);
    repeat (7) @(negedge clk);
    sof_pulse();
    check("R10 relock", int'(locked), 1);
    check("R10 count", int'(frame_count), 7);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule